// File: doc/BRIEF.md
# Lockable Vendor Capability Register Block

This block holds a small vendor-defined extended capability inside a device's configuration space. Configuration software reaches it through 32-bit accesses with per-byte enables. Each access addresses one dword, given by a dword index into the 4 KiB configuration space. The capability opens with a standard extended-capability header that chains to the next capability through the `next_cap_ptr` input. A second header dword gives the structure's length in bytes, its revision and the vendor identifier. The body holds a control word, a sticky status byte, a lock bit and a set of memory-range base registers.

Per-bit write masks decide which bits software can change. Setting the lock bit freezes the control word and every range base until the next reset. A warm reset clears the control word, the lock and the ranges, and leaves the status flags as they are. A cold reset clears everything. The placement parameter `CAP_BASE` must be a dword-aligned offset of at least 0x100, and `CAP_BASE` plus the structure length must stay below 0x1000. The length is 4·(5+2·NUM_RANGES) bytes, 36 by default.

Top module: `vcap_lock_regs`

## Requirements
- R1: The dword at relative slot 0 reads {next_cap_ptr[11:0] in bits 31:20, 4'h1 in bits 19:16, EXT_CAP_ID in bits 15:0}. Slot 1 reads {structure length in bytes (12 bits) in bits 31:20, REVISION in bits 19:16, VENDOR_ID in bits 15:0}. Slot k is at dword index CAP_BASE/4+k. Both header dwords are read-only.
- R2: A read request is answered in the next cycle. In that cycle `rsp_valid` is 1 and `rsp_rdata` holds the addressed dword. Outside those answer cycles `rsp_valid` is 0. Dwords outside the capability's slots read as zero, and writes to them change nothing.
- R3: Slot 2 holds the control word in bits 31:16, with write mask 0x4FFD. Bits 15:0 of slot 2 read STRUCT_ID and are read-only. The `ctrl_out` port shows bits 31:16 of slot 2.
- R4: A byte lane whose byte enable is 0 keeps its old value, whatever the write data.
- R5: Range r has its high base dword at slot 5+2r, which is fully writable. Its low base dword is at slot 6+2r, where only bits 31:28 are writable. `range_base[64r+63:64r]` shows {high, low}.
- R6: Slot 3 bits 3:0 are status flags. A flag is set by a one-cycle pulse on `status_set`. A flag is cleared by writing 1 to it with byte enable 0 asserted. Writing 0 has no effect. Bits 31:4 of slot 3 read 0. If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Slot 4 bit 0 is the lock. Writing 1 to it with byte enable 0 sets it. Writing 0 to it is ignored. Once set, it stays set until a reset. The `locked` port shows its value.
- R8: While the lock is set, writes to the control word and to all range bases have no effect. The status flags can still be cleared.
- R9: While warm reset is asserted, the control word, the ranges and the lock clear and the status flags keep their values. Cold reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold reset, clears all state |
| warm_rst_n | input | 1 | Active-low warm reset, keeps status flags |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw_addr | input | 10 | Dword index into configuration space |
| req_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| req_wdata | input | 32 | Write data |
| next_cap_ptr | input | 12 | Offset of the next capability in the list |
| status_set | input | 4 | Event pulses that set the status flags |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| locked | output | 1 | Lock bit |
| ctrl_out | output | 16 | Current control word |
| range_base | output | 128 | {high, low} base of each range, range 0 in the low 64 bits |

## Verification
A write takes effect at the clock edge that samples the request. The register ports show the new value straight after that edge, and a status pulse acts at the same edge. A read answer appears one edge after the read request and lasts exactly one cycle. The bench drives every access on a falling edge and samples answers and ports on the next falling edge, so each result is read half a cycle after the edge that produced it. Resets are asynchronous, so the bench checks the reset state directly at the falling edge after reset is released.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANES     = WORD_W / 8;
  localparam int unsigned SLOT_HDR0 = 0;
  localparam int unsigned SLOT_HDR1 = 1;
  localparam int unsigned SLOT_CTRL = 2;
  localparam int unsigned SLOT_STAT = 3;
  localparam int unsigned SLOT_LOCK = 4;
  localparam int unsigned SLOT_RNG0 = 5;
  localparam int unsigned STAT_W    = 4;

  // Expand byte enables into a bit mask.
  function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Bits that a write may change: enabled lanes and writable bits.
  function automatic logic [WORD_W-1:0] eff_mask(input logic [LANES-1:0] be,
                                                 input logic [WORD_W-1:0] wmask);
    return lane_bits(be) & wmask;
  endfunction

  // Ordinary masked write.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] wdata,
                                                   input logic [LANES-1:0]  be,
                                                   input logic [WORD_W-1:0] wmask);
    logic [WORD_W-1:0] m;
    m = eff_mask(be, wmask);
    return (old & ~m) | (wdata & m);
  endfunction
endpackage

// File: rtl/vcap_decode.sv
module vcap_decode #(
  parameter int unsigned CAP_BASE  = 12'h100,
  parameter int unsigned NUM_SLOTS = 9,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [9:0]           dw_addr,
  output logic                 hit,
  output logic [SLOT_W-1:0]    slot,
  output logic [NUM_SLOTS-1:0] wr_sel
);
  localparam logic [9:0] BASE_DW = 10'(CAP_BASE >> 2);

  logic [9:0] rel;
  assign rel  = dw_addr - BASE_DW;
  assign hit  = (dw_addr >= BASE_DW) && (rel < 10'(NUM_SLOTS));
  assign slot = rel[SLOT_W-1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    assign wr_sel[s] = req_valid && req_write && hit && (slot == SLOT_W'(s));
  end

  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |-> (wr_sel == '0));
endmodule

// File: rtl/vcap_field_reg.sv
module vcap_field_reg
  import vcap_pkg::*;
#(
  parameter logic [WORD_W-1:0] WMASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              lock_i,
  output logic [WORD_W-1:0] q
);
  logic wr_ok;
  assign wr_ok = wr_en && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_ok) q <= merge_word(q, wdata, be, WMASK);
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  assert_frozen_when_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(q));
endmodule

// File: rtl/vcap_status.sv
module vcap_status
  import vcap_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              wr_en,
  input  logic              be0,
  input  logic [STAT_W-1:0] wbits,
  input  logic [STAT_W-1:0] set_i,
  output logic [STAT_W-1:0] q
);
  logic [STAT_W-1:0] clr;
  assign clr = (wr_en && be0) ? wbits : '0;

  // A set in the same cycle overrides a clear, so no event is lost.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) q <= '0;
    else             q <= (q & ~clr) | set_i;
  end

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
  assert_no_silent_clear_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !wr_en |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/vcap_lock.sv
module vcap_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic be0,
  input  logic wbit,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     q <= 1'b0;
    else if (wr_en && be0 && wbit)  q <= 1'b1;
  end

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> q);
  assert_lock_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !wr_en) |=> !q);
endmodule

// File: rtl/vcap_lock_regs.sv
module vcap_lock_regs
  import vcap_pkg::*;
#(
  parameter int unsigned CAP_BASE    = 12'h100,
  parameter int unsigned NUM_RANGES  = 2,
  parameter logic [15:0] EXT_CAP_ID  = 16'h0023,
  parameter logic [15:0] VENDOR_ID   = 16'h1D5C,
  parameter logic [3:0]  REVISION    = 4'h2,
  parameter logic [15:0] STRUCT_ID   = 16'h0007,
  localparam int unsigned NUM_SLOTS  = SLOT_RNG0 + 2 * NUM_RANGES,
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS),
  localparam logic [11:0] CAP_LEN    = 12'(4 * NUM_SLOTS),
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h4FFD_0000,
  localparam logic [WORD_W-1:0] HI_MASK   = 32'hFFFF_FFFF,
  localparam logic [WORD_W-1:0] LO_MASK   = 32'hF000_0000
) (
  input  logic                     clk,
  input  logic                     cold_rst_n,
  input  logic                     warm_rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [9:0]               req_dw_addr,
  input  logic [3:0]               req_be,
  input  logic [31:0]              req_wdata,
  input  logic [11:0]              next_cap_ptr,
  input  logic [3:0]               status_set,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic                     locked,
  output logic [15:0]              ctrl_out,
  output logic [NUM_RANGES*64-1:0] range_base
);
  logic soft_rst_n;
  assign soft_rst_n = cold_rst_n & warm_rst_n;

  logic                 hit;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_SLOTS-1:0] wr_sel;
  logic [WORD_W-1:0]    slot_word [NUM_SLOTS];

  vcap_decode #(.CAP_BASE(CAP_BASE), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .clk(clk), .rst_n(soft_rst_n), .req_valid(req_valid), .req_write(req_write),
    .dw_addr(req_dw_addr), .hit(hit), .slot(slot), .wr_sel(wr_sel));

  // Header dwords
  assign slot_word[SLOT_HDR0] = {next_cap_ptr, 4'h1, EXT_CAP_ID};
  assign slot_word[SLOT_HDR1] = {CAP_LEN, REVISION, VENDOR_ID};

  // Lock
  logic lock_q;
  vcap_lock u_lock (
    .clk(clk), .rst_n(soft_rst_n), .wr_en(wr_sel[SLOT_LOCK]),
    .be0(req_be[0]), .wbit(req_wdata[0]), .q(lock_q));
  assign slot_word[SLOT_LOCK] = {31'b0, lock_q};
  assign locked = lock_q;

  // Status flags (cold reset only)
  logic [STAT_W-1:0] stat_q;
  vcap_status u_stat (
    .clk(clk), .cold_rst_n(cold_rst_n), .wr_en(wr_sel[SLOT_STAT]),
    .be0(req_be[0]), .wbits(req_wdata[STAT_W-1:0]), .set_i(status_set), .q(stat_q));
  assign slot_word[SLOT_STAT] = {{(WORD_W-STAT_W){1'b0}}, stat_q};

  // Control word
  logic [WORD_W-1:0] ctrl_q;
  vcap_field_reg #(.WMASK(CTRL_MASK)) u_ctrl (
    .clk(clk), .rst_n(soft_rst_n), .wr_en(wr_sel[SLOT_CTRL]), .be(req_be),
    .wdata(req_wdata), .lock_i(lock_q), .q(ctrl_q));
  assign slot_word[SLOT_CTRL] = ctrl_q | {16'b0, STRUCT_ID};
  assign ctrl_out = ctrl_q[31:16];

  // Range bases
  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam int unsigned S_HI = SLOT_RNG0 + 2 * r;
    localparam int unsigned S_LO = S_HI + 1;
    logic [WORD_W-1:0] hi_q, lo_q;
    vcap_field_reg #(.WMASK(HI_MASK)) u_hi (
      .clk(clk), .rst_n(soft_rst_n), .wr_en(wr_sel[S_HI]), .be(req_be),
      .wdata(req_wdata), .lock_i(lock_q), .q(hi_q));
    vcap_field_reg #(.WMASK(LO_MASK)) u_lo (
      .clk(clk), .rst_n(soft_rst_n), .wr_en(wr_sel[S_LO]), .be(req_be),
      .wdata(req_wdata), .lock_i(lock_q), .q(lo_q));
    assign slot_word[S_HI] = hi_q;
    assign slot_word[S_LO] = lo_q;
    assign range_base[64*r +: 64] = {hi_q, lo_q};
  end

  // Registered read path
  logic        rd_req;
  logic [31:0] rd_word;
  assign rd_req  = req_valid && !req_write;
  assign rd_word = hit ? slot_word[slot] : '0;

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end

  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!soft_rst_n)
    rd_req |=> rsp_valid);
  assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (!soft_rst_n)
    !rd_req |=> !rsp_valid);
endmodule

// File: tb/vcap_lock_regs_test.sv
`timescale 1ns/1ps
module vcap_lock_regs_test;
  logic         clk = 1'b0;
  logic         cold_rst_n = 1'b0;
  logic         warm_rst_n = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [9:0]   req_dw_addr = '0;
  logic [3:0]   req_be = '0;
  logic [31:0]  req_wdata = '0;
  logic [11:0]  next_cap_ptr = 12'h000;
  logic [3:0]   status_set = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         locked;
  logic [15:0]  ctrl_out;
  logic [127:0] range_base;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  logic [31:0] sh [0:8];

  vcap_lock_regs uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_dw_addr(req_dw_addr),
    .req_be(req_be), .req_wdata(req_wdata), .next_cap_ptr(next_cap_ptr),
    .status_set(status_set), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .locked(locked), .ctrl_out(ctrl_out), .range_base(range_base));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int off);
    case (off)
      2:       return 32'h4FFD_0000;
      3:       return 32'h0000_000F;
      4:       return 32'h0000_0001;
      5, 7:    return 32'hFFFF_FFFF;
      6, 8:    return 32'hF000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] expect_word(input int off);
    case (off)
      0:       return {next_cap_ptr, 4'h1, 16'h0023};
      1:       return {12'd36, 4'h2, 16'h1D5C};
      2:       return sh[2] | 32'h0000_0007;
      3, 4, 5, 6, 7, 8: return sh[off];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int off);
    case (off)
      0, 1:    return "R1";
      2:       return "R3";
      3:       return "R6";
      4:       return "R7";
      5, 6, 7, 8: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic model_write(input int off, input logic [3:0] be, input logic [31:0] d,
                             input logic [3:0] setv);
    logic [31:0] m;
    m = lanes(be) & wmask(off);
    if (off == 2 || (off >= 5 && off <= 8)) begin
      if (!sh[4][0]) sh[off] = (sh[off] & ~m) | (d & m);
    end else if (off == 3) begin
      sh[3] = sh[3] & ~(d & m);
    end else if (off == 4) begin
      sh[4] = sh[4] | (d & m);
    end
    sh[3] = sh[3] | {28'b0, setv};
  endtask

  task automatic wr(input int off, input logic [3:0] be, input logic [31:0] d,
                    input logic [3:0] setv);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dw_addr = 10'(64 + off);
    req_be = be; req_wdata = d; status_set = setv;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; status_set = '0;
    model_write(off, be, d, setv);
  endtask

  task automatic rd_check(input int off, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dw_addr = 10'(64 + off); req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    check({"R2 valid ", req}, {127'b0, rsp_valid}, 128'd1);
    check(req, {96'b0, rsp_rdata}, {96'b0, expect_word(off)});
  endtask

  task automatic check_ports(input string req);
    check({req, " ctrl_out"}, {112'b0, ctrl_out}, {112'b0, sh[2][31:16]});
    check({req, " range_base"}, range_base, {sh[7], sh[8], sh[5], sh[6]});
    check({req, " locked"}, {127'b0, locked}, {127'b0, sh[4][0]});
  endtask

  initial begin
    for (int i = 0; i < 9; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);

    // Reset state, header and out-of-range reads
    check("R2 idle valid", {127'b0, rsp_valid}, 128'd0);
    for (int off = -1; off <= 9; off++) rd_check(off, {tag_of(off), " reset"});
    check_ports("R9 reset");
    @(negedge clk);
    check("R2 valid drops", {127'b0, rsp_valid}, 128'd0);

    // Sweep every slot (lock excluded) over all byte-enable patterns
    for (int off = -1; off <= 9; off++) begin
      if (off != 4) begin
        for (int b = 0; b < 16; b++) begin
          wr(off, 4'(b), 32'hC3A5_96F0 ^ (32'(b) * 32'h1111_1111) ^ 32'(off + 7), 4'h0);
          rd_check(off, {tag_of(off), " R4 sweep"});
        end
      end
    end
    check_ports("R3 R5 sweep");

    // Header follows the chaining input
    next_cap_ptr = 12'hABC;
    rd_check(0, "R1 next pointer");

    // Status flags: set, clear, no-effect writes, set over clear
    wr(20, 4'hF, 32'h0, 4'b1011);
    rd_check(3, "R6 set");
    wr(3, 4'hE, 32'hFFFF_FFFF, 4'h0);
    rd_check(3, "R6 R4 clear without lane 0");
    wr(3, 4'h1, 32'h0000_0003, 4'h0);
    rd_check(3, "R6 clear ones");
    wr(3, 4'h1, 32'h0000_0000, 4'h0);
    rd_check(3, "R6 write zero");
    wr(3, 4'h1, 32'h0000_0008, 4'b1000);
    rd_check(3, "R6 set beats clear");
    wr(3, 4'h1, 32'h0000_00F0, 4'b0100);
    rd_check(3, "R6 upper bits read zero");

    // Lock behaviour
    wr(2, 4'hF, 32'h1234_5678, 4'h0);
    wr(6, 4'hF, 32'hFFFF_FFFF, 4'h0);
    wr(4, 4'hF, 32'hFFFF_FFFE, 4'h0);
    rd_check(4, "R7 write zero ignored");
    wr(4, 4'hE, 32'hFFFF_FFFF, 4'h0);
    rd_check(4, "R7 R4 lane disabled");
    wr(4, 4'h1, 32'h0000_0001, 4'h0);
    rd_check(4, "R7 set");
    check("R7 locked port", {127'b0, locked}, 128'd1);
    wr(4, 4'hF, 32'h0, 4'h0);
    rd_check(4, "R7 stays set");
    for (int off = 2; off <= 8; off++) begin
      if (off != 3 && off != 4) begin
        wr(off, 4'hF, ~expect_word(off), 4'h0);
        rd_check(off, "R8 frozen");
      end
    end
    check_ports("R8 frozen ports");
    wr(3, 4'h1, 32'h0000_0004, 4'h0);
    rd_check(3, "R8 status clear while locked");
    wr(20, 4'hF, 32'h0, 4'b0011);

    // Warm reset: status survives
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    sh[2] = '0; sh[4] = '0; sh[5] = '0; sh[6] = '0; sh[7] = '0; sh[8] = '0;
    for (int off = 2; off <= 8; off++) rd_check(off, "R9 warm");
    check_ports("R9 warm ports");
    wr(2, 4'hF, 32'hFFFF_FFFF, 4'h0);
    rd_check(2, "R9 R3 writable after warm");

    // Cold reset: all clear
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    for (int i = 0; i < 9; i++) sh[i] = '0;
    for (int off = 2; off <= 8; off++) rd_check(off, "R9 cold");
    check_ports("R9 cold ports");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule